// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and a parallel flash array and watches the stream of write cycles (word address plus data byte) aimed at the array. It recognises the coded write sequences for a single-word program, a whole-array erase and a one-sector erase. When a sequence completes, it raises a one-cycle strobe that tells the program or erase engines what to do. Engines, array storage and status readout live elsewhere. Their busy flag comes back in as an input, and while it is high every write is dropped.

For repeated programming, the decoder offers a fast mode that skips the unlock handshake. Once this mode is entered, each word needs only a command write followed by the address/data write. A two-write exit pair returns the decoder to normal array reads. A `mode` output tells the rest of the chip whether the decoder is idle in read-array state, partway through a coded sequence, or in the fast mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high `rst` sets `mode` to read array (2'b00) and holds all three strobes low.
- R2: The unlock pair is data AAh with the low 11 address bits equal to 555h, then data 55h with the low 11 address bits equal to 2AAh. While a sequence is partly received, `mode` is 2'b01. A mismatch on either unlock write returns `mode` to 2'b00.
- R3: Unlock pair, then A0h at 555h, then any write: `prog_stb` pulses in the cycle after that last write, carrying its address on `prog_addr` and its data on `prog_data`. `mode` then returns to 2'b00.
- R4: Unlock pair, 80h at 555h, unlock pair, 10h at 555h: `bulk_stb` pulses in the cycle after the sixth write, and `mode` returns to 2'b00.
- R5: Unlock pair, 80h at 555h, unlock pair, then 30h at any address: `sect_stb` pulses in the cycle after the sixth write. `sect_idx` carries the top log2(SECTORS) bits of that write's address.
- R6: In an erase sequence, a write whose data or checked address does not match the expected value aborts the sequence with no strobe, and `mode` returns to 2'b00.
- R7: Unlock pair followed by 20h at 555h enters the fast mode, and `mode` becomes 2'b10.
- R8: In fast mode, a write of data A0h (any address) followed by any write pulses `prog_stb` with that second write's address and data. The decoder stays in fast mode.
- R9: In fast mode, a write whose data is neither A0h nor 90h produces no strobe and leaves `mode` at 2'b10.
- R10: In fast mode, data 90h then data 00h (addresses ignored) returns `mode` to 2'b00. A 90h followed by any other data leaves the decoder in fast mode.
- R11: A write while `busy` is high produces no strobe and leaves the sequence position and `mode` unchanged.
- R12: Each strobe is high for exactly one cycle, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Program/erase engine busy; writes are ignored |
| prog_stb | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address to program |
| prog_data | output | DATA_W | Data to program |
| bulk_stb | output | 1 | One-cycle whole-array erase request |
| sect_stb | output | 1 | One-cycle sector erase request |
| sect_idx | output | SECT_W | Sector to erase |
| mode | output | 2 | 00 read array, 01 sequence in progress, 10 fast program mode |

## Verification
The program path is driven twice: once through the full unlock handshake and once through the fast mode, with different addresses and data, so that a strobe fired from the wrong state or a misplaced capture of the payload shows up. Erase is run to completion with both confirm codes, and with the sector address chosen so that its top bits select a non-zero sector. It is also run with a corrupted data byte and with a corrupted address, which separates a decoder that checks every write from one that checks only some. In fast mode, stray codes, a 90h followed by a non-zero byte, and a proper exit with arbitrary addresses show that the mode is left only by the right pair. Busy writes placed in the middle of a sequence prove that the position is frozen, not reset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    // Width of the address field compared against the unlock keys
    localparam int KEY_W = 11;
    localparam logic [KEY_W-1:0] KEY_A = 11'h555;
    localparam logic [KEY_W-1:0] KEY_B = 11'h2AA;

    // Command byte codes
    localparam logic [7:0] CODE_UNL1  = 8'hAA;
    localparam logic [7:0] CODE_UNL2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_FAST  = 8'h20;
    localparam logic [7:0] CODE_BULK  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_EXIT1 = 8'h90;
    localparam logic [7:0] CODE_EXIT2 = 8'h00;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_ERS0,
        S_ERS1,
        S_ERS2,
        S_FAST,
        S_FAST_PROG,
        S_FAST_EXIT
    } seq_state_t;

    typedef enum logic [1:0] {
        M_READ = 2'b00,
        M_CMD  = 2'b01,
        M_FAST = 2'b10
    } mode_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_PROG,
        EV_BULK,
        EV_SECT
    } event_t;

    // Classification of one write cycle
    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_unl1;
        logic d_unl2;
        logic d_prog;
        logic d_erase;
        logic d_fast;
        logic d_bulk;
        logic d_sect;
        logic d_exit1;
        logic d_exit2;
    } wr_class_t;

    function automatic mode_t mode_of(input seq_state_t s);
        case (s)
            S_READ:                          return M_READ;
            S_FAST, S_FAST_PROG, S_FAST_EXIT: return M_FAST;
            default:                         return M_CMD;
        endcase
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [KEY_W-1:0]  key_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_class_t         cls
);

    function automatic logic is_code(input logic [DATA_W-1:0] d, input logic [7:0] c);
        return d == DATA_W'(c);
    endfunction

    always_comb begin
        cls.at_a    = (key_addr == KEY_A);
        cls.at_b    = (key_addr == KEY_B);
        cls.d_unl1  = is_code(wr_data, CODE_UNL1);
        cls.d_unl2  = is_code(wr_data, CODE_UNL2);
        cls.d_prog  = is_code(wr_data, CODE_PROG);
        cls.d_erase = is_code(wr_data, CODE_ERASE);
        cls.d_fast  = is_code(wr_data, CODE_FAST);
        cls.d_bulk  = is_code(wr_data, CODE_BULK);
        cls.d_sect  = is_code(wr_data, CODE_SECT);
        cls.d_exit1 = is_code(wr_data, CODE_EXIT1);
        cls.d_exit2 = is_code(wr_data, CODE_EXIT2);
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       busy,
    input  wr_class_t  cls,
    output seq_state_t state,
    output event_t     evt,
    output mode_t      mode
);

    seq_state_t nxt;
    logic       accept;

    assign accept = wr_en && !busy;
    assign mode   = mode_of(state);

    always_comb begin
        nxt = state;
        evt = EV_NONE;
        if (accept) begin
            case (state)
                S_READ: begin
                    if (cls.at_a && cls.d_unl1) nxt = S_UNL1;
                end
                S_UNL1: begin
                    nxt = (cls.at_b && cls.d_unl2) ? S_UNL2 : S_READ;
                end
                S_UNL2: begin
                    if (cls.at_a && cls.d_prog)       nxt = S_PROG;
                    else if (cls.at_a && cls.d_erase) nxt = S_ERS0;
                    else if (cls.at_a && cls.d_fast)  nxt = S_FAST;
                    else                              nxt = S_READ;
                end
                S_PROG: begin
                    nxt = S_READ;
                    evt = EV_PROG;
                end
                S_ERS0: begin
                    nxt = (cls.at_a && cls.d_unl1) ? S_ERS1 : S_READ;
                end
                S_ERS1: begin
                    nxt = (cls.at_b && cls.d_unl2) ? S_ERS2 : S_READ;
                end
                S_ERS2: begin
                    nxt = S_READ;
                    if (cls.at_a && cls.d_bulk) evt = EV_BULK;
                    else if (cls.d_sect)        evt = EV_SECT;
                end
                S_FAST: begin
                    if (cls.d_prog)       nxt = S_FAST_PROG;
                    else if (cls.d_exit1) nxt = S_FAST_EXIT;
                end
                S_FAST_PROG: begin
                    nxt = S_FAST;
                    evt = EV_PROG;
                end
                S_FAST_EXIT: begin
                    nxt = cls.d_exit2 ? S_READ : S_FAST;
                end
                default: nxt = S_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_READ;
        else     state <= nxt;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> state == S_READ);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(state));

    // R9
    fast_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FAST && accept && !cls.d_prog && !cls.d_exit1) |=> mode == M_FAST);

    // R10
    fast_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_FAST_EXIT && accept && cls.d_exit2) |=> mode == M_READ);

endmodule

// File: rtl/fcd_strobe_gen.sv
module fcd_strobe_gen
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  event_t            evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              bulk_stb,
    output logic              sect_stb,
    output logic [SECT_W-1:0] sect_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_stb  <= 1'b0;
            bulk_stb  <= 1'b0;
            sect_stb  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
            sect_idx  <= '0;
        end else begin
            prog_stb <= (evt == EV_PROG);
            bulk_stb <= (evt == EV_BULK);
            sect_stb <= (evt == EV_SECT);
            if (evt == EV_PROG) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (evt == EV_SECT) begin
                sect_idx <= wr_addr[ADDR_W-1 -: SECT_W];
            end
        end
    end

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_stb, bulk_stb, sect_stb}));

    // R12
    prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        prog_stb |=> !prog_stb);

    // R12
    erase_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (bulk_stb || sect_stb) |=> !(bulk_stb || sect_stb));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SECTORS = 8,
    localparam int SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              bulk_stb,
    output logic              sect_stb,
    output logic [SECT_W-1:0] sect_idx,
    output logic [1:0]        mode
);

    wr_class_t  cls;
    seq_state_t state;
    event_t     evt;
    mode_t      mode_q;

    fcd_classify #(
        .DATA_W(DATA_W)
    ) u_classify (
        .key_addr(wr_addr[KEY_W-1:0]),
        .wr_data (wr_data),
        .cls     (cls)
    );

    fcd_seq_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .busy (busy),
        .cls  (cls),
        .state(state),
        .evt  (evt),
        .mode (mode_q)
    );

    fcd_strobe_gen #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SECT_W(SECT_W)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .prog_stb (prog_stb),
        .prog_addr(prog_addr),
        .prog_data(prog_data),
        .bulk_stb (bulk_stb),
        .sect_stb (sect_stb),
        .sect_idx (sect_idx)
    );

    assign mode = mode_q;

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> !(prog_stb || bulk_stb || sect_stb));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (mode == 2'b00 && !prog_stb && !bulk_stb && !sect_stb));

    // R6
    idle_after_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (bulk_stb || sect_stb) |-> mode == 2'b00);

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SECTORS = 8;
    localparam int SECT_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy = 1'b0;
    logic              prog_stb, bulk_stb, sect_stb;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic [SECT_W-1:0] sect_idx;
    logic [1:0]        mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTORS(SECTORS)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
        .bulk_stb(bulk_stb), .sect_stb(sect_stb), .sect_idx(sect_idx), .mode(mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write cycle; returns just after the capturing edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    function automatic logic [31:0] strobes();
        return {29'd0, prog_stb, bulk_stb, sect_stb};
    endfunction

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mode after reset", mode, 2'b00);
        chk("R1 strobes after reset", strobes(), 0);
        rst = 1'b0;
    endtask

    task automatic t_std_prog();
        wr(16'h0555, 8'hAA);
        chk("R2 mode after first unlock", mode, 2'b01);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'hA0);
        chk("R3 no strobe before payload", strobes(), 0);
        wr(16'h1234, 8'h5A);
        chk("R3 prog strobe", prog_stb, 1);
        chk("R3 prog addr", prog_addr, 16'h1234);
        chk("R3 prog data", prog_data, 8'h5A);
        chk("R3 mode back to read", mode, 2'b00);
        chk("R12 exclusive", strobes(), 3'b100);
        idle_cycle();
        chk("R12 prog pulse one cycle", prog_stb, 0);
    endtask

    task automatic t_unlock_bad();
        wr(16'h0555, 8'hAA);
        wr(16'h02AB, 8'h55);
        chk("R2 bad unlock address", mode, 2'b00);
        wr(16'h0555, 8'hAB);
        chk("R2 bad unlock data", mode, 2'b00);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h56);
        chk("R2 bad second data", mode, 2'b00);
        wr(16'h4000, 8'h12);
        chk("R2 no strobe after abort", strobes(), 0);
    endtask

    task automatic t_bulk();
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
        chk("R4 mode mid erase", mode, 2'b01);
        wr(16'h0555, 8'h10);
        chk("R4 bulk strobe", bulk_stb, 1);
        chk("R12 bulk exclusive", strobes(), 3'b010);
        chk("R4 mode after bulk", mode, 2'b00);
        idle_cycle();
        chk("R12 bulk pulse one cycle", bulk_stb, 0);
    endtask

    task automatic t_sector();
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
        wr(16'hA000, 8'h30);
        chk("R5 sector strobe", sect_stb, 1);
        chk("R5 sector index", sect_idx, 3'd5);
        chk("R12 sector exclusive", strobes(), 3'b001);
        idle_cycle();
        chk("R12 sector pulse one cycle", sect_stb, 0);
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
        wr(16'hE123, 8'h30);
        chk("R5 top sector index", sect_idx, 3'd7);
    endtask

    task automatic t_erase_abort();
        unlock();
        wr(16'h0555, 8'h80);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h54);
        chk("R6 abort on bad data", mode, 2'b00);
        unlock();
        wr(16'h0555, 8'h80);
        wr(16'h0556, 8'hAA);
        chk("R6 abort on bad address", mode, 2'b00);
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
        wr(16'h0555, 8'h11);
        chk("R6 bad confirm no strobe", strobes(), 0);
        chk("R6 bad confirm mode", mode, 2'b00);
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
        wr(16'h0554, 8'h10);
        chk("R6 bulk confirm wrong address", strobes(), 0);
    endtask

    task automatic t_fast();
        unlock();
        wr(16'h0555, 8'h20);
        chk("R7 fast mode entered", mode, 2'b10);
        wr(16'h7777, 8'hA0);
        chk("R8 no strobe on command", strobes(), 0);
        wr(16'h0042, 8'h77);
        chk("R8 fast prog strobe", prog_stb, 1);
        chk("R8 fast prog addr", prog_addr, 16'h0042);
        chk("R8 fast prog data", prog_data, 8'h77);
        chk("R8 stays fast", mode, 2'b10);
        wr(16'h0000, 8'hA0);
        wr(16'hBEEF, 8'hC3);
        chk("R8 second fast prog addr", prog_addr, 16'hBEEF);
        chk("R8 second fast prog data", prog_data, 8'hC3);
        wr(16'h0555, 8'hAA);
        chk("R9 unlock ignored no strobe", strobes(), 0);
        chk("R9 unlock ignored mode", mode, 2'b10);
        wr(16'h0555, 8'h80);
        chk("R9 erase code ignored", mode, 2'b10);
        wr(16'h0123, 8'h90);
        wr(16'h0321, 8'h13);
        chk("R10 partial exit stays fast", mode, 2'b10);
        wr(16'h5555, 8'h90);
        wr(16'hAAAA, 8'h00);
        chk("R10 exit to read", mode, 2'b00);
        wr(16'h1111, 8'h22);
        chk("R10 plain write after exit no strobe", strobes(), 0);
    endtask

    task automatic t_busy();
        busy = 1'b1;
        wr(16'h0555, 8'hAA);
        chk("R11 busy unlock ignored", mode, 2'b00);
        busy = 1'b0;
        unlock();
        wr(16'h0555, 8'hA0);
        busy = 1'b1;
        wr(16'h0300, 8'h44);
        chk("R11 busy payload no strobe", strobes(), 0);
        chk("R11 busy keeps position", mode, 2'b01);
        busy = 1'b0;
        wr(16'h0301, 8'h45);
        chk("R11 program after busy", prog_stb, 1);
        chk("R11 program addr after busy", prog_addr, 16'h0301);
        unlock();
        wr(16'h0555, 8'h20);
        busy = 1'b1;
        wr(16'h0000, 8'h90);
        wr(16'h0000, 8'h00);
        chk("R11 busy in fast mode", mode, 2'b10);
        busy = 1'b0;
        wr(16'h0000, 8'h90);
        wr(16'h0000, 8'h00);
        chk("R11 exit after busy", mode, 2'b00);
    endtask

    initial begin
        t_reset();
        t_std_prog();
        t_unlock_bad();
        t_bulk();
        t_sector();
        t_erase_abort();
        t_fast();
        t_busy();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset from idle", mode, 2'b00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule